// File: doc/BRIEF.md
# Carry-Save Unsigned Multiplier

This block multiplies two unsigned operands and stops short of the final carry-propagate addition. It returns the product as a pair of redundant terms: a sum row and a carry row. Their arithmetic sum equals the product. Several such products can therefore be merged in a later compression tree, and that tree finishes with a single shared adder.

The two operand widths are set independently. The caller should put the narrower operand, or a constant, on the `b` input, because the number of partial-product rows equals the width of `b`. Both output terms are two bits wider than the combined operand width.

A parameter selects one optional register stage on the outputs. When the stage is on, a valid flag travels with the data. When it is off, the block is purely combinational and the flag passes straight through.

Top module: `csa_mult`

## Requirements
- R1: For every operand pair, `(sum_o + carry_o) mod 2^(A_W+B_W+2)` equals `a*b`.
- R2: The combined value of the two terms never sets the two most significant output bits, because the product fits in `A_W+B_W` bits.
- R3: With `REG_OUT=1`, results and `out_valid` appear exactly one clock after the accepting edge at which `in_valid` is high.
- R4: With `REG_OUT=1`, an active-low reset drives `out_valid`, `sum_o` and `carry_o` to zero.
- R5: With `REG_OUT=0`, the outputs follow the operands in the same cycle, and `out_valid` equals `in_valid`.
- R6: If either operand is zero, both `sum_o` and `carry_o` are zero.
- R7: Bit 0 of `carry_o` is always zero.
- R8: With `REG_OUT=1`, an edge with `in_valid` low leaves `sum_o` and `carry_o` unchanged and drives `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on `a` and `b` are valid |
| a | input | A_W | Wider unsigned operand |
| b | input | B_W | Narrower unsigned operand; sets the row count |
| out_valid | output | 1 | Output terms are valid |
| sum_o | output | A_W+B_W+2 | Sum row of the redundant product |
| carry_o | output | A_W+B_W+2 | Carry row of the redundant product |

## Verification
The bench builds two instances with `A_W=5` and `B_W=3`: one with the output register and one without. Both instances see all 256 operand pairs. At this size every partial-product row and every full-adder stage of the chain is exercised, and so are the zero-operand cases and the all-ones pair, where carries travel furthest. The registered instance is also held idle while its operands change, which exposes the hold and latency behaviour.

// File: rtl/csa_mult.sv
module csa_mult #(
  parameter int A_W     = 8,
  parameter int B_W     = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [A_W-1:0]         a,
  input  logic [B_W-1:0]         b,
  output logic                   out_valid,
  output logic [A_W+B_W+1:0]     sum_o,
  output logic [A_W+B_W+1:0]     carry_o
);
  localparam int OW = A_W + B_W + 2;

  logic [OW-1:0] a_ext;
  logic [OW-1:0] pp    [B_W];
  logic [OW-1:0] row_s [B_W];
  logic [OW-1:0] row_c [B_W];
  logic [OW-1:0] s_comb, c_comb;

  assign a_ext = OW'(a);

  genvar i;
  generate
    for (i = 0; i < B_W; i++) begin : g_pp
      assign pp[i] = {OW{b[i]}} & (a_ext << i);
    end

    assign row_s[0] = pp[0];
    assign row_c[0] = '0;

    for (i = 1; i < B_W; i++) begin : g_red
      if (i == 1) begin : g_first
        assign row_s[i] = row_s[0];
        assign row_c[i] = pp[1];
      end else begin : g_fa
        assign row_s[i] = row_s[i-1] ^ row_c[i-1] ^ pp[i];
        assign row_c[i] = ((row_s[i-1] & row_c[i-1]) |
                           (row_s[i-1] & pp[i])      |
                           (row_c[i-1] & pp[i])) << 1;
      end
    end
  endgenerate

  assign s_comb = row_s[B_W-1];
  assign c_comb = row_c[B_W-1];

  logic [OW-1:0] tot_w;
  logic [OW-1:0] prod_w;
  assign tot_w  = sum_o + carry_o;
  assign prod_w = a_ext * OW'(b);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          sum_o     <= '0;
          carry_o   <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            sum_o   <= s_comb;
            carry_o <= c_comb;
          end
        end
      end

      // R1
      product_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (tot_w == $past(prod_w)));
      // R3
      valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      // R8
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(sum_o) && $stable(carry_o)));
      // R6
      zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (a == '0 || b == '0)) |=> (sum_o == '0 && carry_o == '0));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign sum_o     = s_comb;
      assign carry_o   = c_comb;

      // R1
      product_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tot_w == prod_w);
      // R6
      zero_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a == '0 || b == '0) |-> (sum_o == '0 && carry_o == '0));
    end
  endgenerate

  // R7
  carry_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o[0] == 1'b0);
  // R2
  top_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tot_w[OW-1:OW-2] == 2'b00);
endmodule

// File: tb/sim_csa_mult.sv
module sim_csa_mult;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int BW = 3;
  localparam int OW = AW + BW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vin = 1'b0;
  logic [AW-1:0] a = '0;
  logic [BW-1:0] b = '0;
  logic vo0, vo1;
  logic [OW-1:0] s0, c0, s1, c1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csa_mult #(.A_W(AW), .B_W(BW), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .a(a), .b(b),
    .out_valid(vo0), .sum_o(s0), .carry_o(c0));

  csa_mult #(.A_W(AW), .B_W(BW), .REG_OUT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .a(a), .b(b),
    .out_valid(vo1), .sum_o(s1), .carry_o(c1));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tot(input logic [OW-1:0] s, input logic [OW-1:0] c);
    return (int'(s) + int'(c)) % (1 << OW);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R4: reset state of the registered instance
    chk("R4 valid", int'(vo0), 0);
    chk("R4 sum", int'(s0), 0);
    chk("R4 carry", int'(c0), 0);
    rst_n = 1'b1;
    for (int ia = 0; ia < (1 << AW); ia++) begin
      for (int ib = 0; ib < (1 << BW); ib++) begin
        @(negedge clk);
        a = AW'(ia); b = BW'(ib); vin = 1'b1;
        #1;
        // R5: combinational instance follows in the same cycle
        chk("R5 valid", int'(vo1), 1);
        chk("R5/R1 comb product", tot(s1, c1), ia * ib);
        chk("R7 comb carry lsb", int'(c1[0]), 0);
        @(negedge clk);
        // R3: registered result one clock later
        chk("R3 valid", int'(vo0), 1);
        chk("R1 product", tot(s0, c0), ia * ib);
        chk("R2 top bits", tot(s0, c0) >> (OW - 2), 0);
        chk("R7 carry lsb", int'(c0[0]), 0);
        if (ia == 0 || ib == 0) begin
          chk("R6 sum zero", int'(s0), 0);
          chk("R6 carry zero", int'(c0), 0);
          chk("R6 comb zero", int'(s1) + int'(c1), 0);
        end
      end
    end
    // R8: idle edges leave the registered terms untouched
    @(negedge clk);
    a = 5'd31; b = 3'd7; vin = 1'b1;
    @(negedge clk);
    chk("R1 max product", tot(s0, c0), 217);
    vin = 1'b0; a = 5'd3; b = 3'd2;
    @(negedge clk);
    chk("R8 valid low", int'(vo0), 0);
    chk("R8 hold", tot(s0, c0), 217);
    @(negedge clk);
    chk("R8 hold again", tot(s0, c0), 217);
    chk("R5 valid follows", int'(vo1), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule